// File: doc/BRIEF.md
# NMI Response Watchdog Counter

This block sets a deadline for software to service a pending non-maskable fault. A flag controller elsewhere drives a single fault-pending signal. While that signal is high, a 16-bit up-counter advances by one on every clock. When the signal is low, the counter is held at zero. When the registered count equals a programmable period, the block issues a one-cycle system reset request and returns the counter to zero. A reset sequencer outside this block acts on the request.

Software sees two 32-bit registers. The first is a read-only view of the counter. The second is the period register, which accepts a write only when the upper half-word of the write data carries the unlock value 0x9238. If the period is lowered below the current count, the counter keeps running, wraps through zero and fires on the next equality with the new period.

Top module: `nmi_deadline_wdog`

## Requirements
- R1: While `faultPending` is high and the count does not equal the period, the count rises by exactly one per clock and wraps from 0xFFFF to 0x0000.
- R2: At the clock edge after `faultPending` is sampled low, the count is 0, and it stays 0 while the signal stays low.
- R3: When `faultPending` is high and the registered count equals the registered period at a clock edge, `resetReq` is high for the following cycle and the count is 0 in that same cycle. A period written at that same edge does not suppress the request.
- R4: After reset, the count is 0, the period is 0xFFFF and `resetReq` is low.
- R5: A write strobe with `wrData[31:16]` equal to 0x9238 loads `wrData[15:0]` into the period. With any other value in those bits, the period is left unchanged.
- R6: `cntRdata` carries the count in bits 15:0 and `prdRdata` carries the period in bits 15:0. Bits 31:16 of both read as 0.
- R7: If the period is lowered below the current count, no request occurs until the count has wrapped through zero and reached the new period.
- R8: With a period of 0, a request is raised at the first clock edge that samples `faultPending` high, while the count is 0.
- R9: With a nonzero period, `resetReq` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| faultPending | input | 1 | High while any enabled fault flag is pending |
| prdWrEn | input | 1 | Write strobe for the period register |
| wrData | input | 32 | Write data: unlock value in 31:16, period in 15:0 |
| cntRdata | output | 32 | Counter register read value |
| prdRdata | output | 32 | Period register read value |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
A period write and a deadline match can fall on the same clock edge. The bench provokes this by programming a period of 5 and starting the fault. It then asserts a correctly keyed write of period 10 in the cycle whose closing edge sees the count at 5. The request must appear at the cycle computed from the old period, with the count at zero. The next request must then come eleven edges later, which shows that the new period took effect only after the match.

// File: rtl/nmi_wd_pkg.sv
package nmi_wd_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned KEY_W   = BUS_W - CNT_W;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h9238;

  typedef struct packed {
    logic prdLoad;
    logic cntClear;
    logic cntInc;
  } wdStrobes_t;
endpackage

// File: rtl/nmi_wd_ctrl.sv
module nmi_wd_ctrl
  import nmi_wd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultPending,
  input  logic             prdWrEn,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             match,
  output wdStrobes_t       strb,
  output logic             resetReq
);
  logic keyOk;
  logic fire;

  assign keyOk = (wrKey == UNLOCK_KEY);
  assign fire  = faultPending && match;

  always_comb begin
    strb          = '0;
    strb.prdLoad  = prdWrEn && keyOk;
    strb.cntClear = !faultPending || match;
    strb.cntInc   = faultPending && !match;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= fire;
  end
endmodule

// File: rtl/nmi_wd_datapath.sv
module nmi_wd_datapath
  import nmi_wd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strb,
  input  logic [CNT_W-1:0] newPrd,
  output logic             match,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntInc)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prd <= '1;
    else if (strb.prdLoad) prd <= newPrd;
  end

  assign match = (cnt == prd);
endmodule

// File: rtl/nmi_deadline_wdog.sv
module nmi_deadline_wdog
  import nmi_wd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultPending,
  input  logic             prdWrEn,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] cntRdata,
  output logic [BUS_W-1:0] prdRdata,
  output logic             resetReq
);
  wdStrobes_t       strb;
  logic             match;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prd;

  nmi_wd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .faultPending (faultPending),
    .prdWrEn      (prdWrEn),
    .wrKey        (wrData[BUS_W-1:CNT_W]),
    .match        (match),
    .strb         (strb),
    .resetReq     (resetReq)
  );

  nmi_wd_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .newPrd (wrData[CNT_W-1:0]),
    .match  (match),
    .cnt    (cnt),
    .prd    (prd)
  );

  assign cntRdata = {{KEY_W{1'b0}}, cnt};
  assign prdRdata = {{KEY_W{1'b0}}, prd};
endmodule

// File: rtl/nmi_deadline_wdog_chk.sv
module nmi_deadline_wdog_chk
  import nmi_wd_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             faultPending,
  input logic             prdWrEn,
  input logic [BUS_W-1:0] wrData,
  input logic [BUS_W-1:0] cntRdata,
  input logic [BUS_W-1:0] prdRdata,
  input logic             resetReq
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (faultPending && cntRdata[CNT_W-1:0] != prdRdata[CNT_W-1:0])
      |=> cntRdata[CNT_W-1:0] == CNT_W'($past(cntRdata[CNT_W-1:0]) + 1'b1));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !faultPending |=> cntRdata == '0);

  a_r3_fire: assert property (@(posedge clk) disable iff (!rstN)
    (faultPending && cntRdata[CNT_W-1:0] == prdRdata[CNT_W-1:0])
      |=> (resetReq && cntRdata == '0));

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (cntRdata[CNT_W-1:0] != prdRdata[CNT_W-1:0] || !faultPending) |=> !resetReq);

  a_r5_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (prdWrEn && wrData[BUS_W-1:CNT_W] != UNLOCK_KEY) |=> $stable(prdRdata));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntRdata[BUS_W-1:CNT_W] == '0) && (prdRdata[BUS_W-1:CNT_W] == '0));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && prdRdata[CNT_W-1:0] != '0) |=> !resetReq);
endmodule

bind nmi_deadline_wdog nmi_deadline_wdog_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .faultPending (faultPending),
  .prdWrEn      (prdWrEn),
  .wrData       (wrData),
  .cntRdata     (cntRdata),
  .prdRdata     (prdRdata),
  .resetReq     (resetReq)
);

// File: tb/sim_nmi_deadline_wdog.sv
module sim_nmi_deadline_wdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultPending = 1'b0;
  logic        prdWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] cntRdata;
  logic [31:0] prdRdata;
  logic        resetReq;

  int          cyc = 0;
  int          nChecks = 0;
  int          nErrors = 0;
  int          expQ[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nmi_deadline_wdog u0 (
    .clk(clk), .rstN(rstN), .faultPending(faultPending), .prdWrEn(prdWrEn),
    .wrData(wrData), .cntRdata(cntRdata), .prdRdata(prdRdata), .resetReq(resetReq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expectPulse(input int atCyc);
    expQ.push_back(atCyc);
  endtask

  // monitor: every observed request is matched against the expected queue
  always @(negedge clk) begin
    if (rstN && resetReq) begin
      if (expQ.size() == 0) check(1'b0, "R3/R9 unexpected request", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R3 request cycle", cyc, e);
        check(cntRdata == 32'h0, "R3 count zero with request", cntRdata, 0);
      end
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writePrd(input logic [15:0] key, input logic [15:0] val);
    @(negedge clk);
    prdWrEn = 1'b1;
    wrData  = {key, val};
    @(negedge clk);
    prdWrEn = 1'b0;
    wrData  = '0;
  endtask

  initial begin
    int c;
    waitCyc(2);
    check(cntRdata == 32'h0, "R4 count reset", cntRdata, 0);
    check(prdRdata == 32'h0000FFFF, "R4 period reset", prdRdata, 32'hFFFF);
    check(resetReq == 1'b0, "R4 request low", resetReq, 0);
    rstN = 1'b1;
    waitCyc(5);
    check(cntRdata == 32'h0, "R2 idle holds zero", cntRdata, 0);

    writePrd(16'h1234, 16'h0004);
    check(prdRdata == 32'h0000FFFF, "R5 wrong key ignored", prdRdata, 32'hFFFF);
    writePrd(16'h9238, 16'h0004);
    check(prdRdata == 32'h00000004, "R5/R6 keyed write", prdRdata, 4);

    // main deadline, period 4
    @(negedge clk);
    c = cyc;
    faultPending = 1'b1;
    expectPulse(c + 5);
    expectPulse(c + 10);
    waitCyc(2);
    check(cntRdata == 32'h2, "R1 count advances", cntRdata, 2);
    waitCyc(9);
    faultPending = 1'b0;
    waitCyc(1);
    check(cntRdata == 32'h0, "R2 cleared on release", cntRdata, 0);

    // fault released mid count: no request
    faultPending = 1'b1;
    waitCyc(3);
    check(cntRdata == 32'h3, "R1 partial count", cntRdata, 3);
    faultPending = 1'b0;
    waitCyc(1);
    check(cntRdata == 32'h0, "R2 release mid count", cntRdata, 0);
    waitCyc(8);

    // write landing on the match edge
    writePrd(16'h9238, 16'h0005);
    @(negedge clk);
    c = cyc;
    faultPending = 1'b1;
    expectPulse(c + 6);
    expectPulse(c + 17);
    waitCyc(5);
    prdWrEn = 1'b1;
    wrData  = {16'h9238, 16'h000A};
    waitCyc(1);
    prdWrEn = 1'b0;
    wrData  = '0;
    check(prdRdata == 32'h0000000A, "R3/R5 period after same-edge write", prdRdata, 10);
    waitCyc(12);
    faultPending = 1'b0;
    waitCyc(3);

    // period zero
    writePrd(16'h9238, 16'h0000);
    @(negedge clk);
    c = cyc;
    faultPending = 1'b1;
    expectPulse(c + 1);
    waitCyc(1);
    faultPending = 1'b0;
    waitCyc(3);
    check(resetReq == 1'b0, "R8 no further request", resetReq, 0);

    // period lowered below count: wrap then match
    writePrd(16'h9238, 16'hFFFF);
    @(negedge clk);
    c = cyc;
    faultPending = 1'b1;
    waitCyc(100);
    check(cntRdata == 32'd100, "R1 long count", cntRdata, 100);
    prdWrEn = 1'b1;
    wrData  = {16'h9238, 16'd50};
    waitCyc(1);
    prdWrEn = 1'b0;
    wrData  = '0;
    expectPulse(c + 65587);
    waitCyc(65536 - 101);
    check(cntRdata == 32'h0, "R1/R7 wrap to zero", cntRdata, 0);
    waitCyc(3);
    check(cntRdata == 32'h3, "R7 counting after wrap", cntRdata, 3);
    waitCyc(50);
    faultPending = 1'b0;
    waitCyc(2);

    check(expQ.size() == 0, "R3/R7 all expected requests seen", expQ.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule